// File: doc/BRIEF.md
# ADC Sample Averager and Result Formatter

This block sits between a conversion sequencer and the software-visible result of an analog-to-digital converter. Each raw sample arrives with a one-cycle valid strobe. When averaging is switched off, every sample becomes a result. When averaging is on, the block adds up a group of 4, 8, 16 or 32 consecutive samples and reports their mean as one result. It tells the sequencer that the group is complete with a one-cycle pulse.

Each result is cut down to the selected resolution and written into a result register, and a completion flag is raised. A read strobe clears the flag. An overwrite control decides what happens when a new result arrives while the previous one is still unread: the new result either replaces it or is dropped. A conversion-request input clears any partly built group, so the next group starts from zero.

Top module: `adc_avg_fmt`

## Requirements
- R1: After reset the result register is 0, the completion flag is 0 and the group-done pulse is 0.
- R2: With averaging disabled, every accepted sample forms a result by itself. The group-done pulse is high in the cycle after the sample edge, and the result and flag update one cycle after that.
- R3: With averaging enabled, the count select values 2'b00, 2'b01, 2'b10 and 2'b11 set the group size to 4, 8, 16 and 32 samples. The result is the sum of the group divided by the group size, rounded down.
- R4: The stored result is masked according to the resolution mode: 2'b00 keeps the low 8 bits (0xFF), 2'b01 keeps the low 10 bits (0x3FF), and both 2'b10 and 2'b11 keep all 12 bits (0xFFF).
- R5: The group-done pulse and the rise of the completion flag happen only after the last sample of a group. Earlier samples in the group produce neither.
- R6: A group of 32 full-scale samples (0xFFF each) accumulates without overflow and gives 0xFFF.
- R7: With overwrite disabled, a new result that arrives while the flag is set and no read is in progress is discarded. The result register and the flag stay unchanged.
- R8: With overwrite enabled, a new result replaces an unread one.
- R9: A conversion request clears the accumulator and the sample counter. A sample presented in the same cycle as the request is ignored.
- R10: A read strobe clears the completion flag. If a new result arrives in the same cycle as the read, the new result is stored and the flag stays set, even with overwrite disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Conversion request; clears any partly built group |
| smp_valid | input | 1 | Raw sample strobe |
| smp_data | input | 12 | Raw sample value |
| avg_en | input | 1 | Averaging enable |
| avg_sel | input | 2 | Group size select (4/8/16/32 samples) |
| res_mode | input | 2 | Resolution mode (8/10/12 bit) |
| ovr_en | input | 1 | Allow a new result to replace an unread one |
| rd_strobe | input | 1 | Result read; clears the completion flag |
| result | output | 12 | Stored, masked result |
| done_flag | output | 1 | Completion flag |
| grp_done | output | 1 | One-cycle pulse when a group is complete |

## Verification
The bench uses the default parameters: 12-bit samples, a two-bit group select and a minimum group of four samples. With these values the largest group is 32 samples, and the accumulator has to be 17 bits wide. This lets the bench drive a full-scale 32-sample group and check that the sum does not overflow. It also runs every group size and every resolution mode. The no-overwrite, read-with-new-result and restart-mid-group cases are driven directly, because random traffic alone would rarely produce them.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;
    typedef enum logic [1:0] {
        RES_8   = 2'b00,
        RES_10  = 2'b01,
        RES_12  = 2'b10,
        RES_12X = 2'b11
    } res_mode_e;
endpackage

// File: rtl/adc_avg_accum.sv
module adc_avg_accum #(
    parameter int DATA_W  = 12,
    parameter int SEL_W   = 2,
    parameter int MIN_LOG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic              avg_en_i,
    input  logic [SEL_W-1:0]  avg_sel_i,
    output logic [DATA_W-1:0] mean_o,
    output logic              done_o
);
    localparam int MAX_LOG = MIN_LOG + (1 << SEL_W) - 1;
    localparam int ACC_W   = DATA_W + MAX_LOG;
    localparam int CNT_W   = MAX_LOG;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] mean;
        logic              done;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] shifted;
    logic [CNT_W:0]   limit;
    int unsigned      shift;

    always_comb begin
        shift   = avg_en_i ? (MIN_LOG + int'(avg_sel_i)) : 0;
        limit   = (CNT_W+1)'(1) << shift;
        sum     = st_q.acc + ACC_W'(smp_data_i);
        shifted = sum >> shift;
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.acc = '0;
            st_d.cnt = '0;
        end else if (smp_valid_i) begin
            if ({1'b0, st_q.cnt} + (CNT_W+1)'(1) >= limit) begin
                st_d.mean = shifted[DATA_W-1:0];
                st_d.done = 1'b1;
                st_d.acc  = '0;
                st_d.cnt  = '0;
            end else begin
                st_d.acc = sum;
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mean_o = st_q.mean;
    assign done_o = st_q.done;

    // R5: a done pulse is always caused by an accepted sample
    a_r5_done_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(smp_valid_i && !start_i));

    // R9: a conversion request empties the group
    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.cnt == '0 && st_q.acc == '0 && !st_q.done));
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store
    import adc_avg_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] mean_i,
    input  logic [1:0]        res_mode_i,
    input  logic              ovr_en_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] result_o,
    output logic              flag_o
);
    localparam logic [DATA_W-1:0] MASK8  = DATA_W'((1 << (DATA_W-4)) - 1);
    localparam logic [DATA_W-1:0] MASK10 = DATA_W'((1 << (DATA_W-2)) - 1);
    localparam logic [DATA_W-1:0] MASK12 = '1;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              flag;
    } store_t;

    store_t st_d, st_q;
    logic   accept;
    logic [DATA_W-1:0] mask;

    always_comb begin
        unique case (res_mode_e'(res_mode_i))
            RES_8:   mask = MASK8;
            RES_10:  mask = MASK10;
            default: mask = MASK12;
        endcase
        accept = done_i && (ovr_en_i || !st_q.flag || rd_i);
        st_d = st_q;
        if (rd_i) st_d.flag = 1'b0;
        if (accept) begin
            st_d.result = mean_i & mask;
            st_d.flag   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.result;
    assign flag_o   = st_q.flag;

    // R7: without overwrite, an unread result is held
    a_r7_hold_unread: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !ovr_en_i && !rd_i) |=> $stable(st_q.result));

    // R10: a read with no new result clears the flag
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done_i) |=> !st_q.flag);

    // R5: the flag rises only on a delivered group result
    a_r5_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(done_i));

    // R4: 8-bit mode leaves the upper bits clear
    a_r4_mask8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && res_mode_i == 2'b00 && (ovr_en_i || !st_q.flag || rd_i))
        |=> (st_q.result[DATA_W-1:DATA_W-4] == '0));
endmodule

// File: rtl/adc_avg_fmt.sv
module adc_avg_fmt #(
    parameter int DATA_W  = 12,
    parameter int SEL_W   = 2,
    parameter int MIN_LOG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              avg_en,
    input  logic [SEL_W-1:0]  avg_sel,
    input  logic [1:0]        res_mode,
    input  logic              ovr_en,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] result,
    output logic              done_flag,
    output logic              grp_done
);
    logic [DATA_W-1:0] mean;
    logic              done;

    adc_avg_accum #(.DATA_W(DATA_W), .SEL_W(SEL_W), .MIN_LOG(MIN_LOG)) i_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (conv_start),
        .smp_valid_i (smp_valid),
        .smp_data_i  (smp_data),
        .avg_en_i    (avg_en),
        .avg_sel_i   (avg_sel),
        .mean_o      (mean),
        .done_o      (done)
    );

    adc_res_store #(.DATA_W(DATA_W)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done),
        .mean_i     (mean),
        .res_mode_i (res_mode),
        .ovr_en_i   (ovr_en),
        .rd_i       (rd_strobe),
        .result_o   (result),
        .flag_o     (done_flag)
    );

    assign grp_done = done;
endmodule

// File: tb/test_adc_avg_fmt.sv
module test_adc_avg_fmt;
    logic clk = 0, rst_n = 0;
    logic conv_start = 0, smp_valid = 0, avg_en = 0, ovr_en = 0, rd_strobe = 0;
    logic [11:0] smp_data = 0;
    logic [1:0] avg_sel = 0, res_mode = 2'b10;
    logic [11:0] result;
    logic done_flag, grp_done;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_avg_fmt i_adc_avg_fmt (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .smp_valid(smp_valid),
        .smp_data(smp_data), .avg_en(avg_en), .avg_sel(avg_sel), .res_mode(res_mode),
        .ovr_en(ovr_en), .rd_strobe(rd_strobe), .result(result),
        .done_flag(done_flag), .grp_done(grp_done)
    );

    function automatic int mask_of(input logic [1:0] m);
        return (m == 2'b00) ? 32'hFF : (m == 2'b01) ? 32'h3FF : 32'hFFF;
    endfunction

    function automatic int grp_size(input logic en, input logic [1:0] s);
        return en ? (4 << s) : 1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [11:0] d);
        smp_valid = 1; smp_data = d;
        @(negedge clk);
        smp_valid = 0;
    endtask

    task automatic start_pulse();
        conv_start = 1;
        @(negedge clk);
        conv_start = 0;
    endtask

    task automatic read_pulse();
        rd_strobe = 1;
        @(negedge clk);
        rd_strobe = 0;
    endtask

    // Runs one group, checks the done pulse, returns the expected masked result
    task automatic run_group(input logic en, input logic [1:0] sel, input logic [1:0] res,
                             input bit full, output int exp_val);
        int n, sum;
        logic [11:0] d;
        avg_en = en; avg_sel = sel; res_mode = res;
        n = grp_size(en, sel);
        sum = 0;
        start_pulse();
        for (int i = 0; i < n; i++) begin
            d = full ? 12'hFFF : 12'($urandom % 4096);
            sum += d;
            push(d);
            if (i < n - 1) chk("R5 no done before last sample", grp_done, 0);
            else           chk("R5/R2 done on last sample", grp_done, 1);
        end
        exp_val = (sum / n) & mask_of(res);
    endtask

    initial begin
        int e, a;
        void'($urandom(32'h1234abcd));
        repeat (3) @(negedge clk);
        chk("R1 reset result", result, 0);
        chk("R1 reset flag", done_flag, 0);
        chk("R1 reset done pulse", grp_done, 0);
        rst_n = 1;
        @(negedge clk);
        ovr_en = 1;

        // R2: single-sample mode, random values, 12-bit
        for (int k = 0; k < 6; k++) begin
            run_group(0, 0, 2'b10, 0, e);
            @(negedge clk);
            chk("R2 single sample result", result, e);
            chk("R2 flag set", done_flag, 1);
            read_pulse();
            chk("R10 read clears flag", done_flag, 0);
        end

        // R3 + R4: every group size with every resolution
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < 4; r++) begin
                run_group(1, 2'(s), 2'(r), 0, e);
                @(negedge clk);
                chk("R3/R4 averaged masked result", result, e);
                read_pulse();
            end
        end

        // R6: 32 full-scale samples
        run_group(1, 2'b11, 2'b10, 1, e);
        @(negedge clk);
        chk("R6 full-scale 32 group", result, 12'hFFF);
        read_pulse();

        // R9: restart mid-group, sample during start ignored
        avg_en = 1; avg_sel = 0; res_mode = 2'b10;
        start_pulse();
        push(12'hFFF); push(12'hFFF);
        conv_start = 1; smp_valid = 1; smp_data = 12'hFFF;
        @(negedge clk);
        conv_start = 0; smp_valid = 0;
        for (int i = 0; i < 4; i++) begin
            push(12'h010);
            if (i < 3) chk("R9 no early done after restart", grp_done, 0);
            else       chk("R9 done after four new samples", grp_done, 1);
        end
        @(negedge clk);
        chk("R9 mean of fresh group", result, 12'h010);
        read_pulse();

        // R7: overwrite disabled drops a new result
        ovr_en = 0; avg_en = 0; res_mode = 2'b10;
        push(12'h111);
        @(negedge clk);
        chk("R7 first result stored", result, 12'h111);
        push(12'h222);
        @(negedge clk);
        chk("R7 unread result kept", result, 12'h111);
        chk("R7 flag still set", done_flag, 1);

        // R10: read in the same cycle as a new result
        push(12'h333);
        rd_strobe = 1;
        @(negedge clk);
        rd_strobe = 0;
        chk("R10 new result stored with read", result, 12'h333);
        chk("R10 flag stays set", done_flag, 1);
        read_pulse();
        chk("R10 flag cleared", done_flag, 0);

        // R8: overwrite enabled replaces unread
        ovr_en = 1;
        push(12'h444);
        @(negedge clk);
        push(12'h555);
        @(negedge clk);
        chk("R8 replaced unread result", result, 12'h555);
        read_pulse();

        // R4 directed: 10-bit mask on a high value
        res_mode = 2'b01;
        push(12'hFFF);
        @(negedge clk);
        a = result;
        chk("R4 10-bit mask", a, 12'h3FF);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule